// File: doc/BRIEF.md
# Byte-Command Keystream Controller

This block is the command sequencer that sits between a byte-wide host link and a ChaCha20 block-function core. The host sends a one-byte opcode and then a fixed-size payload. Three opcodes write the cipher key, the nonce and the block counter into registers that feed the core. The other two opcodes produce output. One emits whole 64-byte blocks of raw keystream. The other takes a run of data bytes and returns each one XORed with the keystream, which serves for both encryption and decryption.

The core receives a single-cycle start pulse. It answers with a done pulse and then serves its sixteen 32-bit result words, selected by a word index from this block. The controller turns these words into bytes and hands each byte to the host link through a send strobe. It withholds the strobe while the link reports busy. During a run of data bytes, a byte that arrives while the next block is being computed is kept in a one-byte holding register and processed once the block is ready.

Top module: `kc_ctrl`

## Requirements
- R1: Opcode 0x01 is followed by 32 bytes. Payload byte i is written to bits [8i+7:8i] of `core_key`.
- R2: Opcode 0x02 is followed by 12 bytes. Payload byte i is written to bits [8i+7:8i] of `core_nonce`.
- R3: Opcode 0x03 is followed by 4 bytes that form `core_ctr` least significant byte first.
- R4: Opcode 0x04 is followed by one count byte N and produces exactly N×64 output bytes. Output byte j of a block is bits [8(j%4)+7:8(j%4)] of core word j/4, so words go in the order 0 to 15 and the low byte of each word comes first.
- R5: Opcode 0x05 is followed by a 16-bit length L, low byte first. Each of the next L input bytes produces one output byte, equal to the input byte XOR the keystream byte at the same position, in the ordering of R4.
- R6: Every command that produces output starts at byte 0 of a block under the current counter. The counter rises by one each time all 64 bytes of a block have been used. A partly used block leaves the counter unchanged.
- R7: In the data phase of opcode 0x05, a byte that arrives while the next block is being computed is held and then processed. No byte is lost.
- R8: `busy` is high from the cycle after an accepted opcode until the command finishes, and low whenever the controller is idle.
- R9: Any opcode other than 0x01 to 0x05 sets `err` in the next cycle and leaves the controller idle with `busy` low. `err` stays high until reset, and the next byte is taken as a new opcode.
- R10: A count N of 0 or a length L of 0 ends the command without output, and `busy` falls in the cycle after the last payload byte.
- R11: `out_send` is never high while `out_busy` is high, and each high cycle of `out_send` carries exactly one byte.
- R12: After reset, `busy`, `err` and `out_send` are low and the key, nonce and counter registers are zero.
- R13: `core_start` is a single-cycle pulse, issued once for each block the controller consumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe, one byte per high cycle |
| in_byte | input | 8 | Input byte |
| out_busy | input | 1 | Host link cannot take a byte this cycle |
| out_send | output | 1 | Output byte is handed over this cycle |
| out_byte | output | 8 | Output byte |
| core_start | output | 1 | Start one block computation |
| core_done | input | 1 | Core result ready pulse |
| core_word_idx | output | 4 | Index of the result word being read |
| core_word | input | 32 | Selected result word |
| core_key | output | 256 | Key register |
| core_nonce | output | 96 | Nonce register |
| core_ctr | output | 32 | Block counter register |
| busy | output | 1 | Controller not idle |
| err | output | 1 | Sticky unknown-opcode flag |

## Verification
Register writes, `busy` and `err` all come from registers. They change one cycle after the byte that causes them is sampled, so the bench reads them at the falling edge that follows the capturing rising edge. Output bytes appear with no fixed latency, because they depend on the core's delay and on how often `out_busy` is asserted. For that reason a behavioural model queues the expected bytes in order, and on every falling edge where `out_send` is high it compares the byte and checks `out_busy`. The counter is compared once each command has drained. The 70-byte XOR run sends each byte immediately after the previous result appears, so byte 64 arrives while the second block is still being computed.

// File: rtl/kc_pkg.sv
package kc_pkg;

    localparam int WORD_W      = 32;
    localparam int BLOCK_WORDS = 16;
    localparam int BLOCK_BYTES = BLOCK_WORDS * (WORD_W / 8);
    localparam int PTR_W       = $clog2(BLOCK_BYTES);
    localparam int WIDX_W      = $clog2(BLOCK_WORDS);
    localparam int IDX_W       = 6;
    localparam int LEN_BYTES   = 2;

    typedef enum logic [7:0] {
        OP_KEY   = 8'h01,
        OP_NONCE = 8'h02,
        OP_CTR   = 8'h03,
        OP_GEN   = 8'h04,
        OP_XOR   = 8'h05
    } opcode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAYLOAD,
        ST_START,
        ST_WAIT,
        ST_RUN
    } state_e;

    typedef enum logic [2:0] {
        TGT_KEY,
        TGT_NONCE,
        TGT_CTR,
        TGT_BLOCKS,
        TGT_LEN
    } target_e;

    typedef struct packed {
        logic             en;
        target_e          tgt;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } wr_t;

    function automatic logic is_known_op(input logic [7:0] b);
        return (b >= OP_KEY) && (b <= OP_XOR);
    endfunction

    function automatic target_e op_target(input logic [7:0] b);
        case (b)
            OP_KEY:   return TGT_KEY;
            OP_NONCE: return TGT_NONCE;
            OP_CTR:   return TGT_CTR;
            OP_GEN:   return TGT_BLOCKS;
            default:  return TGT_LEN;
        endcase
    endfunction

    function automatic logic [7:0] lane_of(input logic [WORD_W-1:0] w, input logic [1:0] lane);
        logic [WORD_W-1:0] sh;
        sh = w >> {lane, 3'b000};
        return sh[7:0];
    endfunction

endpackage

// File: rtl/kc_store.sv
module kc_store
    import kc_pkg::*;
#(
    parameter int KEY_BYTES   = 32,
    parameter int NONCE_BYTES = 12,
    parameter int CTR_BYTES   = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  wr_t                      wr,
    input  logic                     ctr_inc,
    output logic [8*KEY_BYTES-1:0]   key_o,
    output logic [8*NONCE_BYTES-1:0] nonce_o,
    output logic [8*CTR_BYTES-1:0]   ctr_o
);

    for (genvar g = 0; g < KEY_BYTES; g++) begin : g_key
        logic [7:0] kb_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                kb_q <= '0;
            end else if (wr.en && wr.tgt == TGT_KEY && wr.idx == IDX_W'(g)) begin
                kb_q <= wr.data;
            end
        end
        assign key_o[8*g +: 8] = kb_q;
    end

    for (genvar g = 0; g < NONCE_BYTES; g++) begin : g_nonce
        logic [7:0] nb_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                nb_q <= '0;
            end else if (wr.en && wr.tgt == TGT_NONCE && wr.idx == IDX_W'(g)) begin
                nb_q <= wr.data;
            end
        end
        assign nonce_o[8*g +: 8] = nb_q;
    end

    logic [8*CTR_BYTES-1:0] ctr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q <= '0;
        end else if (wr.en && wr.tgt == TGT_CTR) begin
            for (int i = 0; i < CTR_BYTES; i++) begin
                if (wr.idx == IDX_W'(i)) ctr_q[8*i +: 8] <= wr.data;
            end
        end else if (ctr_inc) begin
            ctr_q <= ctr_q + 1'b1;
        end
    end

    assign ctr_o = ctr_q;

    // R6: one consumed block moves the counter by exactly one
    p_ctr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (ctr_inc && !wr.en) |=> (ctr_o == $past(ctr_o) + 1'b1));

endmodule

// File: rtl/kc_hold.sv
module kc_hold (
    input  logic       clk,
    input  logic       rst,
    input  logic       capture_en,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       take,
    output logic       full_o,
    output logic [7:0] data_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full_o <= 1'b0;
            data_o <= '0;
        end else if (capture_en && in_valid) begin
            full_o <= 1'b1;
            data_o <= in_byte;
        end else if (take) begin
            full_o <= 1'b0;
        end
    end

    // R7: a byte is only consumed when one is actually held
    p_take_full_r7: assert property (@(posedge clk) disable iff (rst)
        take |-> full_o);

endmodule

// File: rtl/kc_seq.sv
module kc_seq
    import kc_pkg::*;
#(
    parameter int KEY_BYTES   = 32,
    parameter int NONCE_BYTES = 12,
    parameter int CTR_BYTES   = 4,
    parameter int COUNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              out_busy,
    output logic              out_send,
    output logic [7:0]        out_byte,
    output logic              core_start,
    input  logic              core_done,
    output logic [WIDX_W-1:0] core_word_idx,
    input  logic [WORD_W-1:0] core_word,
    input  logic              hold_full,
    input  logic [7:0]        hold_data,
    output logic              capture_en,
    output logic              take,
    output wr_t               wr,
    output logic              ctr_inc,
    output logic              busy,
    output logic              err
);

    localparam int LEN_W = 8 * LEN_BYTES;

    state_e             state_q;
    target_e            tgt_q;
    logic [IDX_W-1:0]   cnt_q;
    logic [IDX_W-1:0]   need;
    logic [COUNT_W-1:0] blocks_q;
    logic [LEN_W-1:0]   remain_q;
    logic [7:0]         len_lo_q;
    logic               xor_q;
    logic [PTR_W-1:0]   ptr_q;
    logic               err_q;

    logic       fire;
    logic       last_byte;
    logic       last_payload;
    logic [7:0] ks_byte;

    always_comb begin
        case (tgt_q)
            TGT_KEY:    need = IDX_W'(KEY_BYTES);
            TGT_NONCE:  need = IDX_W'(NONCE_BYTES);
            TGT_CTR:    need = IDX_W'(CTR_BYTES);
            TGT_BLOCKS: need = IDX_W'(1);
            default:    need = IDX_W'(LEN_BYTES);
        endcase
    end

    assign last_payload  = (cnt_q == need - 1'b1);
    assign core_word_idx = ptr_q[PTR_W-1:2];
    assign ks_byte       = lane_of(core_word, ptr_q[1:0]);
    assign last_byte     = (ptr_q == PTR_W'(BLOCK_BYTES - 1));
    assign fire          = (state_q == ST_RUN) && !out_busy && (!xor_q || hold_full);
    assign out_send      = fire;
    assign out_byte      = xor_q ? (ks_byte ^ hold_data) : ks_byte;
    assign take          = fire && xor_q;
    assign ctr_inc       = fire && last_byte;
    assign core_start    = (state_q == ST_START);
    assign capture_en    = xor_q && (state_q == ST_START || state_q == ST_WAIT || state_q == ST_RUN);
    assign busy          = (state_q != ST_IDLE);
    assign err           = err_q;

    always_comb begin
        wr.en   = (state_q == ST_PAYLOAD) && in_valid;
        wr.tgt  = tgt_q;
        wr.idx  = cnt_q;
        wr.data = in_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            tgt_q    <= TGT_KEY;
            cnt_q    <= '0;
            blocks_q <= '0;
            remain_q <= '0;
            len_lo_q <= '0;
            xor_q    <= 1'b0;
            ptr_q    <= '0;
            err_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        if (is_known_op(in_byte)) begin
                            tgt_q   <= op_target(in_byte);
                            cnt_q   <= '0;
                            xor_q   <= (in_byte == OP_XOR);
                            state_q <= ST_PAYLOAD;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_PAYLOAD: begin
                    if (in_valid) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (tgt_q == TGT_LEN && cnt_q == '0) len_lo_q <= in_byte;
                        if (last_payload) begin
                            ptr_q <= '0;
                            case (tgt_q)
                                TGT_BLOCKS: begin
                                    blocks_q <= COUNT_W'(in_byte);
                                    state_q  <= (in_byte == 8'd0) ? ST_IDLE : ST_START;
                                end
                                TGT_LEN: begin
                                    remain_q <= {in_byte, len_lo_q};
                                    state_q  <= ({in_byte, len_lo_q} == '0) ? ST_IDLE : ST_START;
                                end
                                default: state_q <= ST_IDLE;
                            endcase
                        end
                    end
                end
                ST_START: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (core_done) state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (fire) begin
                        ptr_q <= ptr_q + 1'b1;
                        if (xor_q) begin
                            remain_q <= remain_q - 1'b1;
                            if (remain_q == LEN_W'(1)) state_q <= ST_IDLE;
                            else if (last_byte)        state_q <= ST_START;
                        end else if (last_byte) begin
                            blocks_q <= blocks_q - 1'b1;
                            state_q  <= (blocks_q == COUNT_W'(1)) ? ST_IDLE : ST_START;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R9: the error flag never falls without reset
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R9: an unknown opcode leaves the controller idle with the flag raised
    p_bad_op_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && in_valid && !is_known_op(in_byte)) |=> (!busy && err));

    // R8: an accepted opcode raises busy in the next cycle
    p_busy_after_op_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && in_valid && is_known_op(in_byte)) |=> busy);

    // R13: the core start request lasts one cycle
    p_start_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start);

    // R4: each delivered byte advances the position by one
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
        out_send |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1)));

    // R10: a zero block count ends the command at once
    p_zero_count_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PAYLOAD && tgt_q == TGT_BLOCKS && in_valid && in_byte == 8'd0) |=> !busy);

endmodule

// File: rtl/kc_ctrl.sv
module kc_ctrl
    import kc_pkg::*;
#(
    parameter int KEY_BYTES   = 32,
    parameter int NONCE_BYTES = 12,
    parameter int CTR_BYTES   = 4,
    parameter int COUNT_W     = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [7:0]               in_byte,
    input  logic                     out_busy,
    output logic                     out_send,
    output logic [7:0]               out_byte,
    output logic                     core_start,
    input  logic                     core_done,
    output logic [WIDX_W-1:0]        core_word_idx,
    input  logic [WORD_W-1:0]        core_word,
    output logic [8*KEY_BYTES-1:0]   core_key,
    output logic [8*NONCE_BYTES-1:0] core_nonce,
    output logic [8*CTR_BYTES-1:0]   core_ctr,
    output logic                     busy,
    output logic                     err
);

    wr_t        wr;
    logic       ctr_inc;
    logic       hold_full;
    logic [7:0] hold_data;
    logic       capture_en;
    logic       take;

    kc_seq #(
        .KEY_BYTES  (KEY_BYTES),
        .NONCE_BYTES(NONCE_BYTES),
        .CTR_BYTES  (CTR_BYTES),
        .COUNT_W    (COUNT_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .out_busy     (out_busy),
        .out_send     (out_send),
        .out_byte     (out_byte),
        .core_start   (core_start),
        .core_done    (core_done),
        .core_word_idx(core_word_idx),
        .core_word    (core_word),
        .hold_full    (hold_full),
        .hold_data    (hold_data),
        .capture_en   (capture_en),
        .take         (take),
        .wr           (wr),
        .ctr_inc      (ctr_inc),
        .busy         (busy),
        .err          (err)
    );

    kc_store #(
        .KEY_BYTES  (KEY_BYTES),
        .NONCE_BYTES(NONCE_BYTES),
        .CTR_BYTES  (CTR_BYTES)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .ctr_inc(ctr_inc),
        .key_o  (core_key),
        .nonce_o(core_nonce),
        .ctr_o  (core_ctr)
    );

    kc_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .capture_en(capture_en),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .take      (take),
        .full_o    (hold_full),
        .data_o    (hold_data)
    );

    // R11: no byte is handed over while the link is busy
    p_no_send_busy_r11: assert property (@(posedge clk) disable iff (rst)
        out_busy |-> !out_send);

endmodule

// File: tb/kc_ctrl_tb_top.sv
module kc_ctrl_tb_top;

    localparam int LAT = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [7:0]   in_byte = '0;
    logic         out_busy = 1'b0;
    logic         out_send;
    logic [7:0]   out_byte;
    logic         core_start;
    logic         core_done;
    logic [3:0]   core_word_idx;
    logic [31:0]  core_word;
    logic [255:0] core_key;
    logic [95:0]  core_nonce;
    logic [31:0]  core_ctr;
    logic         busy;
    logic         err;

    always #2 clk = ~clk;

    kc_ctrl dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .out_busy(out_busy), .out_send(out_send), .out_byte(out_byte),
        .core_start(core_start), .core_done(core_done),
        .core_word_idx(core_word_idx), .core_word(core_word),
        .core_key(core_key), .core_nonce(core_nonce), .core_ctr(core_ctr),
        .busy(busy), .err(err)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    bit throttle = 0;
    int bcnt = 0;
    int starts = 0;

    logic [255:0] m_key = '0;
    logic [95:0]  m_nonce = '0;
    logic [31:0]  m_ctr = '0;

    function automatic logic [31:0] kfun(input logic [255:0] k, input logic [95:0] n,
                                         input logic [31:0] c, input int w);
        logic [31:0] kw;
        logic [31:0] nw;
        kw = k[32*(w%8) +: 32];
        nw = n[32*(w%3) +: 32];
        return kw ^ nw ^ (c * 32'h9E3779B9) ^ (32'(w) * 32'h01010101);
    endfunction

    function automatic logic [7:0] ks(input logic [31:0] c, input int pos);
        logic [31:0] w;
        w = kfun(m_key, m_nonce, c, pos / 4);
        return w[8*(pos%4) +: 8];
    endfunction

    // behavioural core: latches inputs on start, done after LAT cycles
    logic [255:0] lat_key = '0;
    logic [95:0]  lat_nonce = '0;
    logic [31:0]  lat_ctr = '0;
    int           ccnt = 0;
    assign core_word = kfun(lat_key, lat_nonce, lat_ctr, int'(core_word_idx));

    always @(posedge clk) begin
        if (rst) begin
            ccnt <= 0;
            core_done <= 1'b0;
        end else begin
            core_done <= (ccnt == 1);
            if (core_start) begin
                lat_key <= core_key;
                lat_nonce <= core_nonce;
                lat_ctr <= core_ctr;
                ccnt <= LAT;
                starts <= starts + 1;
            end else if (ccnt != 0) begin
                ccnt <= ccnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // output monitor and link model, sampled away from the rising edge
    always @(negedge clk) begin
        if (!rst) begin
            if (out_send) begin
                chk(!out_busy, "R11 send while link busy", 256'(out_busy), 256'(0));
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4/R5 unexpected output byte", 256'(out_byte), 256'(0));
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(out_byte === e, "R4/R5 output byte", 256'(out_byte), 256'(e));
                end
                got_q.push_back(out_byte);
                if (throttle) bcnt = 2;
            end
            out_busy = (bcnt > 0);
            if (bcnt > 0) bcnt--;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        int n = 0;
        while ((exp_q.size() != 0 || busy) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(exp_q.size() == 0 && !busy, req, 256'(exp_q.size()), 256'(0));
    endtask

    task automatic push_gen(input int nb);
        for (int b = 0; b < nb; b++) begin
            for (int p = 0; p < 64; p++) exp_q.push_back(ks(m_ctr, p));
            m_ctr++;
        end
    endtask

    task automatic load_ctr(input logic [31:0] c);
        send_byte(8'h03);
        for (int i = 0; i < 4; i++) send_byte(c[8*i +: 8]);
        m_ctr = c;
    endtask

    // data run: one byte in, wait for its result, next byte at once
    task automatic xor_run(input logic [7:0] data[$], input string req);
        int len = data.size();
        send_byte(8'h05);
        send_byte(len[7:0]);
        send_byte(len[15:8]);
        for (int i = 0; i < len; i++) begin
            int n = 0;
            exp_q.push_back(data[i] ^ ks(m_ctr, i % 64));
            if (i % 64 == 63) m_ctr++;
            send_byte(data[i]);
            while (exp_q.size() != 0 && n < 200) begin
                @(negedge clk);
                n++;
            end
            chk(exp_q.size() == 0, req, 256'(exp_q.size()), 256'(0));
        end
        drain(req);
    endtask

    initial begin
        logic [7:0] d[$];
        logic [7:0] pt[$];
        logic [7:0] ct[$];
        int s0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(!busy && !err && !out_send, "R12 reset flags", {busy, err, out_send}, 256'(0));
        chk(core_key == 0 && core_nonce == 0 && core_ctr == 0, "R12 reset registers",
            core_key ^ 256'(core_nonce) ^ 256'(core_ctr), 256'(0));

        // R1 key load, R8 busy during payload
        send_byte(8'h01);
        chk(busy, "R8 busy after opcode", 256'(busy), 256'(1));
        for (int i = 0; i < 32; i++) begin
            logic [7:0] kb;
            kb = 8'(i * 7 + 3);
            m_key[8*i +: 8] = kb;
            send_byte(kb);
        end
        chk(core_key == m_key, "R1 key layout", core_key, m_key);
        chk(!busy, "R8 idle after load", 256'(busy), 256'(0));

        // R2 nonce load
        send_byte(8'h02);
        for (int i = 0; i < 12; i++) begin
            logic [7:0] nb;
            nb = 8'(8'hA0 + i * 5);
            m_nonce[8*i +: 8] = nb;
            send_byte(nb);
        end
        chk(core_nonce == m_nonce, "R2 nonce layout", 256'(core_nonce), 256'(m_nonce));

        // R3 counter little-endian
        load_ctr(32'h40302010);
        chk(core_ctr == 32'h40302010, "R3 counter byte order", 256'(core_ctr), 256'h40302010);

        // R4 one block, R13 one start
        s0 = starts;
        push_gen(1);
        send_byte(8'h04);
        send_byte(8'h01);
        drain("R4 single block drained");
        chk(core_ctr == m_ctr, "R6 counter after one block", 256'(core_ctr), 256'(m_ctr));
        chk(starts - s0 == 1, "R13 starts for one block", 256'(starts - s0), 256'(1));

        // R4 three blocks with a slow link, R11 R13
        throttle = 1;
        s0 = starts;
        push_gen(3);
        send_byte(8'h04);
        send_byte(8'h03);
        drain("R4 three blocks with link stalls");
        chk(core_ctr == m_ctr, "R6 counter after three blocks", 256'(core_ctr), 256'(m_ctr));
        chk(starts - s0 == 3, "R13 starts for three blocks", 256'(starts - s0), 256'(3));
        throttle = 0;

        // R10 zero count
        send_byte(8'h04);
        send_byte(8'h00);
        chk(!busy, "R10 zero count ends at once", 256'(busy), 256'(0));
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0 && got_q.size() == 256 && core_ctr == m_ctr,
            "R10 zero count gives no output", 256'(got_q.size()), 256'(256));

        // R5 R7 R6: 70 bytes across a block boundary, byte 64 arrives during recompute
        load_ctr(32'h00000100);
        for (int i = 0; i < 70; i++) d.push_back(8'(i * 13 + 1));
        xor_run(d, "R7 XOR run across block boundary");
        chk(core_ctr == 32'h00000101, "R6 partial block leaves counter", 256'(core_ctr), 256'h101);

        // R5 round trip: encrypt then decrypt restores the data
        for (int i = 0; i < 5; i++) pt.push_back(8'(8'h55 + i));
        load_ctr(32'h00000007);
        got_q.delete();
        xor_run(pt, "R5 encrypt pass");
        ct = got_q;
        load_ctr(32'h00000007);
        got_q.delete();
        xor_run(ct, "R5 decrypt pass");
        for (int i = 0; i < 5; i++)
            chk(got_q[i] == pt[i], "R5 round trip byte", 256'(got_q[i]), 256'(pt[i]));
        chk(core_ctr == 32'h7, "R6 short run keeps counter", 256'(core_ctr), 256'h7);

        // R10 zero length
        send_byte(8'h05);
        send_byte(8'h00);
        send_byte(8'h00);
        chk(!busy, "R10 zero length ends at once", 256'(busy), 256'(0));

        // R9 unknown opcodes
        chk(!err, "R9 flag clear before bad opcode", 256'(err), 256'(0));
        send_byte(8'h07);
        chk(err && !busy, "R9 bad opcode flags and stays idle", {err, busy}, 256'b10);
        send_byte(8'h00);
        chk(err && !busy, "R9 zero opcode rejected", {err, busy}, 256'b10);
        load_ctr(32'hCAFE0001);
        chk(core_ctr == 32'hCAFE0001 && err, "R9 next byte is an opcode, flag sticky",
            256'(core_ctr), 256'hCAFE0001);

        // R12 reset clears the flag
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!err && core_ctr == 0, "R12 reset clears flag and counter", {err, core_ctr}, 256'(0));

        summary();
    end

endmodule